// File: doc/BRIEF.md
# I2C Word-Register Target

This block is the serial front end of a chip-level register bank. It watches a two-wire I2C bus as a target and gives a bus controller access to 16-bit internal registers through an 8-bit register pointer. SCL and SDA pass through a two-flop synchronizer. A small event detector turns the synchronized lines into SCL rise, SCL fall, start and stop events. A byte-level state machine then walks each transaction. The 7-bit target address is a fixed base whose two low bits come from two strap inputs.

In a write transaction, the first byte after the address is always the new pointer. Two further bytes, high byte first, form one word that goes to the register file through a single write strobe. That strobe is issued only after the second data byte has been acknowledged. A write that stops right after the pointer only moves the pointer. A read transaction returns the word at the pointer that the last write left in place, high byte first. The pointer does not change on reads. SDA is only ever pulled low, and SCL is never held.

States and transitions:
- S_IDLE waits for a start condition, which leads to S_ADDR.
- S_ADDR shifts in eight bits. On a match it goes to S_ADDR_ACK; otherwise it returns to S_IDLE with no acknowledge.
- S_ADDR_ACK goes to S_RDATA if the R/W bit was high, and to S_PTR if it was low.
- S_PTR goes to S_PTR_ACK, which loads the pointer and then goes to S_WDATA.
- S_WDATA goes to S_WDATA_ACK. After the first data byte this returns to S_WDATA. After the second it commits the word and returns to S_IDLE.
- S_RDATA goes to S_RDATA_ACK, which samples the controller's acknowledge. An ACK after the high byte returns to S_RDATA to send the low byte. Any other case returns to S_IDLE.
- From every state, a stop condition leads to S_IDLE and a start condition leads to S_ADDR.

Top module: `i2c_word_target`

## Requirements
- R1: The target acknowledges (pulls SDA low in the ninth bit) an address byte whose upper seven bits equal {ADDR_BASE[6:2], addr_sel}. For any other address it gives no acknowledge and ignores the rest of that transaction: no pointer change and no register write. The default ADDR_BASE is 7'h40.
- R2: In a write (R/W bit, the address byte LSB, equal to 0), the first byte after the address is acknowledged. It becomes the pointer, which drives reg_addr.
- R3: The two bytes after the pointer are each acknowledged. They form one word, the first byte being bits 15:8. That word is written to the pointed register with reg_we high for exactly one clock cycle, after the second byte's acknowledge.
- R4: A write that holds only the address and pointer bytes updates reg_addr and raises no reg_we.
- R5: In a read (R/W bit 1), the target sends reg_rdata at the pointer, bits 15:8 first, each byte MSB first.
- R6: The pointer keeps its value across read transactions, so repeated reads return the same register.
- R7: After the controller NACKs a read byte, the target releases SDA and does not drive it again until the next start.
- R8: A write that ends after only one data byte leaves the register unchanged and raises no reg_we.
- R9: A start or stop condition in any state ends the transfer and releases SDA. A repeated start begins a new address phase that uses the pointer already set.
- R10: sda_oe (1 = pull SDA low) changes only while SCL is low.
- R11: After reset, sda_oe is 0, reg_we is 0 and reg_addr is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| addr_sel | input | 2 | Strap levels that form the two low address bits |
| reg_addr | output | 8 | Register pointer, the register file address |
| reg_wdata | output | 16 | Word to be written |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 16 | Word at reg_addr, read combinationally |

## Verification
Each bus event reaches the state machine about three clock cycles after the pad changes: two synchronizer stages, then the edge register. An acknowledge or data bit therefore appears on SDA a few cycles after the SCL fall that precedes it. The bench holds SCL low for ten cycles and samples SDA in the middle of the SCL high phase, well after that window. reg_addr changes at the fall that ends the pointer byte, and reg_we fires at the fall that ends the second data acknowledge. The bench therefore compares the pointer, the write count and the register contents only after the closing stop condition.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_PTR,
        S_PTR_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_RDATA_ACK
    } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= '1;
                else        pipe[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= '1;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    assign dout = pipe[STAGES-1];

endmodule

// File: rtl/i2c_line_events.sv
module i2c_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_word_fsm.sv
module i2c_word_fsm
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              sda_s,
    input  logic [6:0]        my_addr,
    input  logic [WORD_W-1:0] reg_rdata,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [WORD_W-1:0] reg_wdata,
    output logic              reg_we,
    output tgt_state_e        state_o
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    tgt_state_e        state_q;
    tgt_state_e        state_d;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] ptr;
    logic [BYTE_W-1:0] hold_hi;
    logic [WORD_W-1:0] wdata;
    logic              rw;
    logic              second;
    logic              ack_rx;
    logic              oe;
    logic              we;
    logic              byte_done;
    logic              addr_hit;

    assign byte_done = scl_fall && (bitcnt == FULL);
    assign addr_hit  = (shreg[BYTE_W-1:1] == my_addr);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_ev) begin
            state_d = S_IDLE;
        end else if (start_ev) begin
            state_d = S_ADDR;
        end else begin
            unique case (state_q)
                S_IDLE: state_d = S_IDLE;
                S_ADDR: begin
                    if (byte_done) state_d = addr_hit ? S_ADDR_ACK : S_IDLE;
                end
                S_ADDR_ACK: begin
                    if (scl_fall) state_d = rw ? S_RDATA : S_PTR;
                end
                S_PTR: begin
                    if (byte_done) state_d = S_PTR_ACK;
                end
                S_PTR_ACK: begin
                    if (scl_fall) state_d = S_WDATA;
                end
                S_WDATA: begin
                    if (byte_done) state_d = S_WDATA_ACK;
                end
                S_WDATA_ACK: begin
                    if (scl_fall) state_d = second ? S_IDLE : S_WDATA;
                end
                S_RDATA: begin
                    if (byte_done) state_d = S_RDATA_ACK;
                end
                S_RDATA_ACK: begin
                    if (scl_fall) state_d = (ack_rx && !second) ? S_RDATA : S_IDLE;
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt  <= '0;
            shreg   <= '0;
            ptr     <= '0;
            hold_hi <= '0;
            wdata   <= '0;
            rw      <= 1'b0;
            second  <= 1'b0;
            ack_rx  <= 1'b0;
            oe      <= 1'b0;
            we      <= 1'b0;
        end else begin
            we <= 1'b0;
            if (stop_ev || start_ev) begin
                oe     <= 1'b0;
                bitcnt <= '0;
                second <= 1'b0;
            end else begin
                unique case (state_q)
                    S_IDLE: oe <= 1'b0;
                    S_ADDR, S_PTR, S_WDATA: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end
                        if (byte_done) begin
                            bitcnt <= '0;
                            if (state_q == S_ADDR) begin
                                rw <= shreg[0];
                                oe <= addr_hit;
                            end else if (state_q == S_PTR) begin
                                ptr <= shreg;
                                oe  <= 1'b1;
                            end else begin
                                if (!second) hold_hi <= shreg;
                                else         wdata   <= {hold_hi, shreg};
                                oe <= 1'b1;
                            end
                        end
                    end
                    S_ADDR_ACK: begin
                        if (scl_fall) begin
                            second <= 1'b0;
                            if (rw) begin
                                shreg <= reg_rdata[WORD_W-1:BYTE_W];
                                oe    <= ~reg_rdata[WORD_W-1];
                            end else begin
                                oe <= 1'b0;
                            end
                        end
                    end
                    S_PTR_ACK: begin
                        if (scl_fall) oe <= 1'b0;
                    end
                    S_WDATA_ACK: begin
                        if (scl_fall) begin
                            oe     <= 1'b0;
                            we     <= second;
                            second <= ~second;
                        end
                    end
                    S_RDATA: begin
                        if (scl_rise) bitcnt <= bitcnt + 1'b1;
                        if (scl_fall) begin
                            if (bitcnt == FULL) begin
                                oe     <= 1'b0;
                                bitcnt <= '0;
                            end else begin
                                shreg <= {shreg[BYTE_W-2:0], 1'b0};
                                oe    <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    S_RDATA_ACK: begin
                        if (scl_rise) ack_rx <= ~sda_s;
                        if (scl_fall) begin
                            if (ack_rx && !second) begin
                                shreg  <= reg_rdata[BYTE_W-1:0];
                                oe     <= ~reg_rdata[BYTE_W-1];
                                second <= 1'b1;
                            end else begin
                                oe <= 1'b0;
                            end
                        end
                    end
                    default: oe <= 1'b0;
                endcase
            end
        end
    end

    assign sda_oe    = oe;
    assign reg_addr  = ptr;
    assign reg_wdata = wdata;
    assign reg_we    = we;
    assign state_o   = state_q;

endmodule

// File: rtl/i2c_word_target.sv
module i2c_word_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] ADDR_BASE   = 7'h40,
    parameter int         SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         scl_i,
    input  logic         sda_i,
    output logic         sda_oe,
    input  logic [1:0]   addr_sel,
    output logic [7:0]   reg_addr,
    output logic [15:0]  reg_wdata,
    output logic         reg_we,
    input  logic [15:0]  reg_rdata
);

    logic [1:0] lines_s;
    logic       scl_s;
    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_ev;
    logic       stop_ev;
    logic [6:0] my_addr;
    tgt_state_e fsm_state;

    assign my_addr = {ADDR_BASE[6:2], addr_sel};

    i2c_line_sync #(
        .STAGES (SYNC_STAGES),
        .W      (2)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_i, sda_i}),
        .dout  (lines_s)
    );

    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    i2c_line_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2c_word_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .sda_s     (sda_s),
        .my_addr   (my_addr),
        .reg_rdata (reg_rdata),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .state_o   (fsm_state)
    );

endmodule

// File: rtl/i2c_word_target_chk.sv
module i2c_word_target_chk
    import i2c_tgt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       sda_oe,
    input logic       start_ev,
    input logic       stop_ev,
    input logic       reg_we,
    input logic [7:0] reg_addr,
    input tgt_state_e fsm_state
);

    // R10: the data line is only switched while the clock is low
    a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R9: bus conditions release the data line
    a_r9_release_on_condition: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev || stop_ev) |=> !sda_oe);

    // R3: the write strobe lasts one cycle
    a_r3_we_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R3: the write strobe follows the acknowledge of a data byte
    a_r3_we_after_data_ack: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $past(fsm_state) == S_WDATA_ACK);

    // R6: the pointer only moves when a pointer byte has been taken
    a_r6_ptr_moves_on_ptr_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_addr) |-> fsm_state == S_PTR_ACK);

endmodule

bind i2c_word_target i2c_word_target_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_oe    (sda_oe),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .fsm_state (fsm_state)
);

// File: tb/i2c_word_target_test.sv
module i2c_word_target_test;

    localparam int CLK_PERIOD = 10;
    localparam int Q = 5;
    localparam int NVEC = 4;
    // {pointer, word}
    localparam logic [23:0] VEC [0:NVEC-1] = '{
        24'h05A5C3, 24'h108001, 24'hFF7E18, 24'h00FFFF
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic [1:0]  addr_sel = 2'b10;
    logic [7:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic        reg_we;
    logic [15:0] reg_rdata;
    logic [15:0] regs [0:255];
    int          we_count;
    int          compared = 0;
    int          mismatched = 0;
    int          viol = 0;
    logic        oe_prev = 1'b0;
    logic        done = 1'b0;
    logic [6:0]  dev;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = regs[reg_addr];

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_word_target uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .addr_sel  (addr_sel),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) regs[i] <= '0;
            we_count <= 0;
        end else if (reg_we) begin
            regs[reg_addr] <= reg_wdata;
            we_count <= we_count + 1;
        end
    end

    // R10 monitor at the ports
    always @(negedge clk) begin
        if (rst_n && scl_m && (sda_oe != oe_prev)) viol = viol + 1;
        oe_prev = sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic get_byte(output logic [7:0] d, input logic ack_it);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(~ack_it);
    endtask

    // write: nb = number of data bytes (0, 1 or 2); acks = {addr, ptr, hi, lo}
    task automatic wr_tx(input logic [7:0] p, input logic [15:0] w, input int nb,
                         input logic do_stop, output logic [3:0] acks);
        logic a;
        acks = 4'b0;
        bus_start;
        put_byte({dev, 1'b0}, a); acks[3] = a;
        put_byte(p, a);           acks[2] = a;
        if (nb > 0) begin put_byte(w[15:8], a); acks[1] = a; end
        if (nb > 1) begin put_byte(w[7:0], a);  acks[0] = a; end
        if (do_stop) bus_stop;
    endtask

    task automatic rd_word(output logic [15:0] w, output logic ack);
        logic [7:0] hi;
        logic [7:0] lo;
        bus_start;
        put_byte({dev, 1'b1}, ack);
        get_byte(hi, 1'b1);
        get_byte(lo, 1'b0);
        bus_stop;
        w = {hi, lo};
    endtask

    initial begin
        logic [3:0]  acks;
        logic [15:0] w;
        logic [7:0]  bt;
        logic        a;
        int          wc0;
        dev = 7'h42;
        tick(5);
        // R11 reset state
        chk("R11 sda_oe after reset", {31'b0, sda_oe}, 32'h0);
        chk("R11 reg_we after reset", {31'b0, reg_we}, 32'h0);
        chk("R11 reg_addr after reset", {24'b0, reg_addr}, 32'h0);
        rst_n = 1'b1;
        tick(5);

        // table walk: write a word, read it back
        for (int v = 0; v < NVEC; v++) begin
            wc0 = we_count;
            wr_tx(VEC[v][23:16], VEC[v][15:0], 2, 1'b1, acks);
            tick(4);
            chk("R3 all four bytes acknowledged", {28'b0, acks}, 32'hF);
            chk("R2 pointer on reg_addr", {24'b0, reg_addr}, {24'b0, VEC[v][23:16]});
            chk("R3 one write strobe", we_count - wc0, 32'd1);
            chk("R3 stored word", {16'b0, regs[VEC[v][23:16]]}, {16'b0, VEC[v][15:0]});
            rd_word(w, a);
            chk("R5 read address ack", {31'b0, a}, 32'h1);
            chk("R5 read word", {16'b0, w}, {16'b0, VEC[v][15:0]});
        end

        // R4 pointer-only write, then R6 repeated reads
        wc0 = we_count;
        wr_tx(8'h10, 16'h0, 0, 1'b1, acks);
        tick(4);
        chk("R4 pointer-only acks", {28'b0, acks[3:2]}, 32'h3);
        chk("R4 pointer moved", {24'b0, reg_addr}, 32'h10);
        chk("R4 no write strobe", we_count - wc0, 32'd0);
        rd_word(w, a);
        chk("R5 read after pointer set", {16'b0, w}, 32'h8001);
        rd_word(w, a);
        chk("R6 second read same register", {16'b0, w}, 32'h8001);
        chk("R6 pointer kept", {24'b0, reg_addr}, 32'h10);

        // R8 write cut after first data byte
        wc0 = we_count;
        wr_tx(8'h05, 16'h1100, 1, 1'b1, acks);
        tick(4);
        chk("R8 no strobe on one data byte", we_count - wc0, 32'd0);
        rd_word(w, a);
        chk("R8 register unchanged", {16'b0, w}, 32'hA5C3);

        // R1 foreign addresses
        dev = 7'h45;
        wc0 = we_count;
        wr_tx(8'h33, 16'h1234, 2, 1'b1, acks);
        tick(4);
        chk("R1 no ack for foreign address", {28'b0, acks}, 32'h0);
        chk("R1 pointer untouched", {24'b0, reg_addr}, 32'h05);
        chk("R1 no strobe", we_count - wc0, 32'd0);
        dev = 7'h41;
        wr_tx(8'h33, 16'h1234, 0, 1'b1, acks);
        tick(4);
        chk("R1 low bits mismatch no ack", {28'b0, acks}, 32'h0);
        addr_sel = 2'b01;
        tick(4);
        wr_tx(8'hFF, 16'h0, 0, 1'b1, acks);
        tick(4);
        chk("R1 strap change ack", {28'b0, acks[3:2]}, 32'h3);
        rd_word(w, a);
        chk("R1 read under new strap", {16'b0, w}, 32'h7E18);
        addr_sel = 2'b10;
        dev = 7'h42;
        tick(4);

        // R7 NACK after first read byte
        bus_start;
        put_byte({dev, 1'b1}, a);
        get_byte(bt, 1'b0);
        chk("R7 high byte before nack", {24'b0, bt}, 32'h7E);
        get_byte(bt, 1'b0);
        chk("R7 line released after nack", {24'b0, bt}, 32'hFF);
        bus_stop;

        // R9 repeated start after pointer byte
        wr_tx(8'h10, 16'h0, 0, 1'b0, acks);
        bus_start;
        put_byte({dev, 1'b1}, a);
        chk("R9 ack after repeated start", {31'b0, a}, 32'h1);
        get_byte(bt, 1'b1);
        w[15:8] = bt;
        get_byte(bt, 1'b0);
        w[7:0] = bt;
        bus_stop;
        chk("R9 read via repeated start", {16'b0, w}, 32'h8001);

        // R9 repeated start in the middle of write data
        wc0 = we_count;
        wr_tx(8'h00, 16'hAA00, 1, 1'b0, acks);
        bus_start;
        put_byte({dev, 1'b1}, a);
        get_byte(bt, 1'b1);
        w[15:8] = bt;
        get_byte(bt, 1'b0);
        w[7:0] = bt;
        bus_stop;
        tick(4);
        chk("R9 no strobe after cut write", we_count - wc0, 32'd0);
        chk("R9 read after cut write", {16'b0, w}, 32'hFFFF);

        // R5 unwritten register reads zero
        wr_tx(8'h33, 16'h0, 0, 1'b1, acks);
        rd_word(w, a);
        chk("R5 unwritten register", {16'b0, w}, 32'h0);

        chk("R10 sda_oe moved while SCL high", viol, 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL R9 watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule